// File: doc/BRIEF.md
# Locality Page Access Gate

This block stands between a memory-mapped request path and the command windows of a security module. The address space it owns is split into five pages of 4 KiB each, one page per privilege locality. Every request that falls inside those pages is either passed on, tagged with its locality number and page offset, or discarded without any error response. The choice depends on whether that locality is currently open.

A small controller sets which localities are open. It reacts to a fixed set of platform security events: a microcode-mode level, entry to and exit from authenticated-code mode, a successful secure launch, and a close request from system software. Locality 0 is always open, and locality 1 follows a separate enable level. The localities have no ranking. An open locality never gives access to a page that belongs to another one. A discarded read returns all ones on the drop data lane so that the requester sees a clean value.

Top module: `loc_page_gate`

## Requirements
- R1: A request whose address lies in the owned region with page index n in 0..4 (page index in address bits 14:12, base `BASE_ADDR` matching bits above 14) is forwarded as locality n with the low 12 address bits as offset. A page index of 5..7, or a mismatching base, produces neither a forward nor a drop.
- R2: Requests to locality 0 are always forwarded.
- R3: Locality 1 follows the `loc1Enable` input, registered once, and is open after reset.
- R4: Locality 2 opens for requests issued after a cycle with `launchOk` high and closes for requests issued after a cycle with `osClose` high. When both are high in the same cycle, the close wins. A request issued in the same cycle as the event still sees the old state.
- R5: Locality 3 opens after a cycle with `acmEnter` high and closes after a cycle with `acmExit` high. When both are high in the same cycle, the exit wins.
- R6: Locality 4 is forwarded only for requests issued while `ucodeMode` is high.
- R7: A request to a closed locality is dropped. `fwdValid` stays low, so a write has no effect, and `dropPulse` is high for one cycle.
- R8: After a dropped read, `dropData` is all ones. After a dropped write, and after any forwarded request, it is zero.
- R9: Localities are unranked. Having locality 3 or 4 open does not open a closed locality 2 or 3.
- R10: Reset closes localities 2 and 3, opens locality 1, and leaves all outputs low.
- R11: The result of a request appears in the cycle after it is issued and lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-on reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Request byte address |
| reqWdata | input | DATA_W | Write data |
| ucodeMode | input | 1 | Microcode/hardware mode level |
| acmEnter | input | 1 | Authenticated-code mode entry strobe |
| acmExit | input | 1 | Authenticated-code mode exit strobe |
| launchOk | input | 1 | Secure launch success strobe |
| osClose | input | 1 | Software close request for locality 2 |
| loc1Enable | input | 1 | Enable level for locality 1 |
| fwdValid | output | 1 | Forwarded request valid |
| fwdWrite | output | 1 | Forwarded request is a write |
| fwdLoc | output | 3 | Locality of the forwarded request |
| fwdOffset | output | 12 | Offset within the locality page |
| fwdWdata | output | DATA_W | Forwarded write data |
| dropPulse | output | 1 | One-cycle flag for a dropped request |
| dropData | output | DATA_W | All ones after a dropped read, else zero |

## Verification
The bench checks the event orderings. It opens and closes each locality and then probes it in the very next request. A controller with the wrong priority would let a launch override a close, or an entry override an exit, in the same cycle. The bench also issues requests in the same cycle as an opening event, which catches a gate that reads the enable state one cycle early. Page indices above four and foreign bases must give neither a forward nor a drop; a loose decoder would alias them onto a real locality. Probes of locality 2 and 3 while higher localities are open catch any ranked shortcut. Reads and writes to closed pages check that a write leaks no forward and that the read fill is all ones, not stale data.

// File: rtl/lpg_pkg.sv
package lpg_pkg;
  localparam int NUM_LOC = 5;
  localparam int LOC_W   = $clog2(NUM_LOC);

  typedef struct packed {
    logic [NUM_LOC-1:0] open;
  } lpg_gate_t;
endpackage

// File: rtl/lpg_ctrl.sv
module lpg_ctrl
  import lpg_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      ucodeMode,
  input  logic      acmEnter,
  input  logic      acmExit,
  input  logic      launchOk,
  input  logic      osClose,
  input  logic      loc1Enable,
  output lpg_gate_t gate
);
  logic loc1Q, loc2Q, loc3Q;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loc1Q <= 1'b1;
      loc2Q <= 1'b0;
      loc3Q <= 1'b0;
    end else begin
      loc1Q <= loc1Enable;
      if (osClose)       loc2Q <= 1'b0;
      else if (launchOk) loc2Q <= 1'b1;
      if (acmExit)       loc3Q <= 1'b0;
      else if (acmEnter) loc3Q <= 1'b1;
    end
  end

  always_comb begin
    gate.open    = '0;
    gate.open[0] = 1'b1;
    gate.open[1] = loc1Q;
    gate.open[2] = loc2Q;
    gate.open[3] = loc3Q;
    gate.open[4] = ucodeMode;
  end
endmodule

// File: rtl/lpg_path.sv
module lpg_path
  import lpg_pkg::*;
#(
  parameter int              ADDR_W     = 24,
  parameter int              DATA_W     = 32,
  parameter int              PAGE_BYTES = 4096,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 24'hD4_0000
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           reqValid,
  input  logic                           reqWrite,
  input  logic [ADDR_W-1:0]              reqAddr,
  input  logic [DATA_W-1:0]              reqWdata,
  input  lpg_gate_t                      gate,
  output logic                           fwdValid,
  output logic                           fwdWrite,
  output logic [LOC_W-1:0]               fwdLoc,
  output logic [$clog2(PAGE_BYTES)-1:0]  fwdOffset,
  output logic [DATA_W-1:0]              fwdWdata,
  output logic                           dropPulse,
  output logic [DATA_W-1:0]              dropData
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int TAG_LO = OFF_W + LOC_W;

  logic [LOC_W-1:0] pageIdx;
  logic             tagHit, inRange, hit, openSel;

  assign pageIdx = reqAddr[TAG_LO-1:OFF_W];
  assign tagHit  = (reqAddr[ADDR_W-1:TAG_LO] == BASE_ADDR[ADDR_W-1:TAG_LO]);
  assign inRange = (32'(pageIdx) < NUM_LOC);
  assign hit     = reqValid && tagHit && inRange;

  always_comb begin
    openSel = 1'b0;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (pageIdx == LOC_W'(i)) openSel = gate.open[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fwdValid  <= 1'b0;
      fwdWrite  <= 1'b0;
      fwdLoc    <= '0;
      fwdOffset <= '0;
      fwdWdata  <= '0;
      dropPulse <= 1'b0;
      dropData  <= '0;
    end else begin
      fwdValid  <= hit && openSel;
      dropPulse <= hit && !openSel;
      dropData  <= (hit && !openSel && !reqWrite) ? '1 : '0;
      if (hit && openSel) begin
        fwdWrite  <= reqWrite;
        fwdLoc    <= pageIdx;
        fwdOffset <= reqAddr[OFF_W-1:0];
        fwdWdata  <= reqWrite ? reqWdata : '0;
      end else begin
        fwdWrite  <= 1'b0;
        fwdLoc    <= '0;
        fwdOffset <= '0;
        fwdWdata  <= '0;
      end
    end
  end
endmodule

// File: rtl/loc_page_gate.sv
module loc_page_gate #(
  parameter int                ADDR_W     = 24,
  parameter int                DATA_W     = 32,
  parameter int                PAGE_BYTES = 4096,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = 24'hD4_0000
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          reqValid,
  input  logic                          reqWrite,
  input  logic [ADDR_W-1:0]             reqAddr,
  input  logic [DATA_W-1:0]             reqWdata,
  input  logic                          ucodeMode,
  input  logic                          acmEnter,
  input  logic                          acmExit,
  input  logic                          launchOk,
  input  logic                          osClose,
  input  logic                          loc1Enable,
  output logic                          fwdValid,
  output logic                          fwdWrite,
  output logic [lpg_pkg::LOC_W-1:0]     fwdLoc,
  output logic [$clog2(PAGE_BYTES)-1:0] fwdOffset,
  output logic [DATA_W-1:0]             fwdWdata,
  output logic                          dropPulse,
  output logic [DATA_W-1:0]             dropData
);
  lpg_pkg::lpg_gate_t gate;

  lpg_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ucodeMode  (ucodeMode),
    .acmEnter   (acmEnter),
    .acmExit    (acmExit),
    .launchOk   (launchOk),
    .osClose    (osClose),
    .loc1Enable (loc1Enable),
    .gate       (gate)
  );

  lpg_path #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .PAGE_BYTES (PAGE_BYTES),
    .BASE_ADDR  (BASE_ADDR)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .gate      (gate),
    .fwdValid  (fwdValid),
    .fwdWrite  (fwdWrite),
    .fwdLoc    (fwdLoc),
    .fwdOffset (fwdOffset),
    .fwdWdata  (fwdWdata),
    .dropPulse (dropPulse),
    .dropData  (dropData)
  );
endmodule

// File: rtl/lpg_checker.sv
module lpg_checker #(
  parameter int                ADDR_W     = 24,
  parameter int                DATA_W     = 32,
  parameter int                PAGE_BYTES = 4096,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = 24'hD4_0000
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      reqValid,
  input logic [ADDR_W-1:0]         reqAddr,
  input logic                      ucodeMode,
  input logic                      acmExit,
  input logic                      osClose,
  input logic                      fwdValid,
  input logic [lpg_pkg::LOC_W-1:0] fwdLoc,
  input logic                      dropPulse,
  input logic [DATA_W-1:0]         dropData
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int TAG_LO = OFF_W + lpg_pkg::LOC_W;

  logic page0Req;
  assign page0Req = reqValid
                 && (reqAddr[ADDR_W-1:TAG_LO] == BASE_ADDR[ADDR_W-1:TAG_LO])
                 && (reqAddr[TAG_LO-1:OFF_W] == '0);

  AST_LOC0_ALWAYS: assert property (@(posedge clk) disable iff (!rstN)
    page0Req |=> (fwdValid && fwdLoc == '0));                              // R2
  AST_LOC_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    fwdValid |-> (fwdLoc < 3'd5));                                         // R1
  AST_FWD_DROP_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(fwdValid && dropPulse));                                             // R7
  AST_RESULT_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (fwdValid || dropPulse) |-> $past(reqValid));                          // R11
  AST_LOC4_NEEDS_UCODE: assert property (@(posedge clk) disable iff (!rstN)
    (fwdValid && fwdLoc == 3'd4) |-> $past(ucodeMode));                    // R6
  AST_LOC3_SHUT_AFTER_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (fwdValid && fwdLoc == 3'd3) |-> !$past(acmExit, 2));                  // R5
  AST_LOC2_SHUT_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rstN)
    (fwdValid && fwdLoc == 3'd2) |-> !$past(osClose, 2));                  // R4
  AST_FILL_ONLY_ON_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (dropData != '0) |-> (dropPulse && dropData == '1));                   // R8
endmodule

bind loc_page_gate lpg_checker #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .PAGE_BYTES (PAGE_BYTES),
  .BASE_ADDR  (BASE_ADDR)
) u_lpg_checker (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqAddr   (reqAddr),
  .ucodeMode (ucodeMode),
  .acmExit   (acmExit),
  .osClose   (osClose),
  .fwdValid  (fwdValid),
  .fwdLoc    (fwdLoc),
  .dropPulse (dropPulse),
  .dropData  (dropData)
);

// File: tb/loc_page_gate_bench.sv
`timescale 1ns/1ps
module loc_page_gate_bench;
  localparam int          ADDR_W = 24;
  localparam int          DATA_W = 32;
  localparam logic [23:0] BASE   = 24'hD4_0000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0, reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic              ucodeMode = 1'b0, acmEnter = 1'b0, acmExit = 1'b0;
  logic              launchOk = 1'b0, osClose = 1'b0, loc1Enable = 1'b1;
  logic              fwdValid, fwdWrite, dropPulse;
  logic [2:0]        fwdLoc;
  logic [11:0]       fwdOffset;
  logic [DATA_W-1:0] fwdWdata, dropData;

  int nRun = 0, nFail = 0;

  always #2 clk = ~clk;

  loc_page_gate u_loc_page_gate (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .ucodeMode(ucodeMode),
    .acmEnter(acmEnter), .acmExit(acmExit), .launchOk(launchOk),
    .osClose(osClose), .loc1Enable(loc1Enable), .fwdValid(fwdValid),
    .fwdWrite(fwdWrite), .fwdLoc(fwdLoc), .fwdOffset(fwdOffset),
    .fwdWdata(fwdWdata), .dropPulse(dropPulse), .dropData(dropData)
  );

  // vector layout: {ucode, write, page[2:0], expFwd, expDrop}
  localparam logic [6:0] VEC [12] = '{
    7'b0_0_000_1_0, 7'b0_1_000_1_0, 7'b0_0_001_1_0, 7'b0_1_010_0_1,
    7'b0_0_010_0_1, 7'b0_0_011_0_1, 7'b0_1_100_0_1, 7'b1_0_100_1_0,
    7'b1_1_011_0_1, 7'b0_0_101_0_0, 7'b0_1_111_0_0, 7'b1_0_000_1_0
  };

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // issue one request at a negedge; results are sampled one cycle later
  task automatic issue(input logic [23:0] base, input int page, input bit wr,
                       input bit uc, input logic [11:0] off);
    @(negedge clk);
    reqValid  = 1'b1;
    reqWrite  = wr;
    reqAddr   = base + (24'(page) << 12) + 24'(off);
    reqWdata  = 32'hA5A5_0000 | 32'(off);
    ucodeMode = uc;
    @(negedge clk);
    reqValid  = 1'b0;
    reqWrite  = 1'b0;
    ucodeMode = 1'b0;
  endtask

  task automatic expectResult(input string tag, input int page, input bit wr,
                              input logic [11:0] off, input bit expFwd, input bit expDrop);
    logic [DATA_W-1:0] expFill;
    expFill = (expDrop && !wr) ? '1 : '0;
    check(fwdValid == expFwd && dropPulse == expDrop, tag, "fwd/drop",
          {fwdValid, dropPulse}, {expFwd, expDrop});
    if (expFwd)
      check(fwdLoc == 3'(page) && fwdOffset == off && fwdWrite == wr, tag,
            "loc/off/wr", {fwdLoc, fwdOffset, fwdWrite}, {3'(page), off, wr});
    check(dropData == expFill, (expDrop ? "R8" : tag), "dropData", dropData, expFill);
  endtask

  task automatic access(input string tag, input int page, input bit wr,
                        input bit uc, input bit expFwd, input bit expDrop);
    issue(BASE, page, wr, uc, 12'h3C4);
    expectResult(tag, page, wr, 12'h3C4, expFwd, expDrop);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: launchOk = 1'b1;
      1: osClose  = 1'b1;
      2: acmEnter = 1'b1;
      3: acmExit  = 1'b1;
      4: begin launchOk = 1'b1; osClose = 1'b1; end
      default: begin acmEnter = 1'b1; acmExit = 1'b1; end
    endcase
    @(negedge clk);
    launchOk = 1'b0; osClose = 1'b0; acmEnter = 1'b0; acmExit = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: outputs quiet during and just after reset
    check(!fwdValid && !dropPulse && dropData == '0, "R10", "reset outputs",
          {fwdValid, dropPulse}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!fwdValid && !dropPulse, "R10", "idle after reset", {fwdValid, dropPulse}, 0);

    // table walk from the reset state: loc0/1 open, loc2/3 closed
    for (int i = 0; i < 12; i++) begin
      logic [6:0] v;
      string tag;
      v = VEC[i];
      if (v[4:2] > 3'd4)       tag = "R1";
      else if (v[4:2] == 3'd4) tag = "R6";
      else if (v[4:2] == 3'd3) tag = "R9";
      else if (v[0])           tag = "R7";
      else                     tag = "R2";
      issue(BASE, int'(v[4:2]), v[5], v[6], 12'h3C4);
      expectResult(tag, int'(v[4:2]), v[5], 12'h3C4, v[1], v[0]);
    end

    // R1: foreign base gives nothing
    issue(BASE ^ 24'h10_0000, 0, 1'b0, 1'b0, 12'h004);
    expectResult("R1", 0, 1'b0, 12'h004, 1'b0, 1'b0);

    // R11: one-cycle result
    issue(BASE, 0, 1'b1, 1'b0, 12'hFFF);
    expectResult("R11", 0, 1'b1, 12'hFFF, 1'b1, 1'b0);
    check(fwdWdata == 32'hA5A5_0FFF, "R11", "wdata", fwdWdata, 32'hA5A5_0FFF);
    @(negedge clk);
    check(!fwdValid && !dropPulse, "R11", "single cycle", {fwdValid, dropPulse}, 0);

    // R3: locality 1 follows its enable
    @(negedge clk); loc1Enable = 1'b0;
    access("R3", 1, 1'b0, 1'b0, 1'b0, 1'b1);
    @(negedge clk); loc1Enable = 1'b1;
    access("R3", 1, 1'b1, 1'b0, 1'b1, 1'b0);

    // R4: event in same cycle as request sees old state
    @(negedge clk);
    launchOk = 1'b1; reqValid = 1'b1; reqWrite = 1'b0;
    reqAddr = BASE + (24'd2 << 12);
    @(negedge clk);
    launchOk = 1'b0; reqValid = 1'b0;
    expectResult("R4", 2, 1'b0, 12'h000, 1'b0, 1'b1);
    access("R4", 2, 1'b1, 1'b0, 1'b1, 1'b0);
    // R9: loc2 open does not open loc3
    access("R9", 3, 1'b0, 1'b0, 1'b0, 1'b1);
    pulse(1);
    access("R4", 2, 1'b0, 1'b0, 1'b0, 1'b1);
    pulse(4);
    access("R4", 2, 1'b0, 1'b0, 1'b0, 1'b1);

    // R5: authenticated-code mode
    pulse(2);
    access("R5", 3, 1'b1, 1'b0, 1'b1, 1'b0);
    access("R9", 2, 1'b1, 1'b1, 1'b0, 1'b1);
    pulse(3);
    access("R5", 3, 1'b0, 1'b0, 1'b0, 1'b1);
    pulse(5);
    access("R5", 3, 1'b0, 1'b0, 1'b0, 1'b1);

    // R10: reset closes 2 and 3, reopens 1
    pulse(0); pulse(2);
    @(negedge clk); loc1Enable = 1'b0;
    @(negedge clk); loc1Enable = 1'b1; rstN = 1'b0;
    @(negedge clk); rstN = 1'b1; loc1Enable = 1'b1;
    access("R10", 2, 1'b0, 1'b0, 1'b0, 1'b1);
    access("R10", 3, 1'b0, 1'b0, 1'b0, 1'b1);
    access("R10", 1, 1'b0, 1'b0, 1'b1, 1'b0);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    nRun++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule